// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column command into the sequence of column indices a synchronous DRAM burst visits, one index per clock. A controller pulses `start_i` with the starting column, a burst-length code and an ordering select. From the next clock on, the block presents one column per cycle on `col_o`, qualified by `valid_o`, and raises `last_o` on the final beat of a fixed-length burst.

The ordering is either sequential or interleaved. Both wrap inside the window of burst-length columns that is aligned to the burst length. A page-length burst instead walks forward through the whole page and wraps there, and it runs until `stop_i` ends it. A new column command may arrive on any clock, including the one right after the previous command, and it replaces the running burst at once. The length code and ordering come in as inputs. They are captured with each command and are not stored anywhere else.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: A clock with `start_i` high makes the next cycle show `valid_o`=1 with `col_o` equal to the start column (beat 0).
- R3: Length code 0 selects 1 beat, 1 selects 2, 2 selects 4, 3 selects 8, and 7 selects page length. Codes 4, 5 and 6 behave as 1 beat. A fixed burst shows exactly that many valid cycles and then `valid_o` falls.
- R4: With `ilv_i`=0 (sequential), beat i shows base + ((s + i) mod BL). Here s is the start column and base is s with its low log2(BL) bits cleared.
- R5: With `ilv_i`=1 (interleaved), beat i shows base with its low log2(BL) bits equal to (s XOR i).
- R6: A page-length burst shows (s + i) mod 512 on beat i, never raises `last_o`, and stays valid until stopped.
- R7: A page-length burst with `ilv_i`=1 follows the sequential order.
- R8: `last_o` is 1 exactly on beat BL-1 of a fixed burst and is 0 on every other cycle.
- R9: `stop_i` high on a clock without `start_i` ends the burst: the next cycle shows `valid_o`=0. A stop while idle has no effect.
- R10: `start_i` on any clock, even during a burst or together with `stop_i`, restarts from beat 0 using the new command's column, length and ordering.
- R11: Changes of `start_col_i`, `len_code_i` and `ilv_i` on clocks without `start_i` do not affect the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Column command strobe |
| start_col_i | input | COL_W (9) | Starting column of the command |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects interleaved ordering |
| stop_i | input | 1 | Burst stop strobe |
| col_o | output | COL_W (9) | Column of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The clocked properties assume that `start_i`, `stop_i` and the command fields have known values on every clock after reset. They also assume that the captured length and ordering change only on a clock with `start_i`. The bench drives every input at the falling edge, so each value is stable across the sampling edge. On idle clocks it deliberately places unrelated values on the command fields, and it combines start with stop. This exercises the capture rule without ever leaving an input undriven.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Burst length codes; unlisted values act as a single beat.
  typedef enum logic [2:0] {
    BLEN_1    = 3'd0,
    BLEN_2    = 3'd1,
    BLEN_4    = 3'd2,
    BLEN_8    = 3'd3,
    BLEN_PAGE = 3'd7
  } blen_code_e;

  localparam int unsigned LEN_CODE_W = 3;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  output logic [COL_W-1:0]      win_mask_o,
  output logic                  page_o
);

  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  always_comb begin
    page_o     = 1'b0;
    win_mask_o = '0;
    case (code_i)
      BLEN_2:    win_mask_o = COL_W'(1);
      BLEN_4:    win_mask_o = COL_W'(3);
      BLEN_8:    win_mask_o = COL_W'(7);
      BLEN_PAGE: begin
        win_mask_o = ALL_ONES;
        page_o     = 1'b1;
      end
      default:   win_mask_o = '0;
    endcase
  end

endmodule

// File: rtl/beat_addr_calc.sv
module beat_addr_calc #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] win_mask_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] beat_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] base;
  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] ilv_low;

  always_comb begin
    base    = start_col_i & ~win_mask_i;
    seq_low = (start_col_i + beat_i) & win_mask_i;
    ilv_low = (start_col_i ^ beat_i) & win_mask_i;
    col_o   = base | (ilv_i ? ilv_low : seq_low);
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o
);

  // captured command
  logic [COL_W-1:0] hold_col;
  logic [COL_W-1:0] hold_mask;
  logic             hold_page;
  logic             hold_ilv;
  logic [COL_W-1:0] beat_q;

  // decoded live command
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;

  // selected command for the next beat
  logic [COL_W-1:0] sel_col;
  logic [COL_W-1:0] sel_mask;
  logic             sel_page;
  logic             sel_ilv;
  logic [COL_W-1:0] beat_nxt;
  logic [COL_W-1:0] col_nxt;
  logic             last_nxt;
  logic             go_on;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i     (len_code_i),
    .win_mask_o (dec_mask),
    .page_o     (dec_page)
  );

  always_comb begin
    sel_col  = start_i ? start_col_i : hold_col;
    sel_mask = start_i ? dec_mask : hold_mask;
    sel_page = start_i ? dec_page : hold_page;
    sel_ilv  = (start_i ? ilv_i : hold_ilv) & ~sel_page;
    beat_nxt = start_i ? '0 : beat_q + COL_W'(1);
    last_nxt = ~sel_page && (beat_nxt == sel_mask);
    go_on    = start_i | (valid_o & ~stop_i & ~last_o);
  end

  beat_addr_calc #(.COL_W(COL_W)) u_calc (
    .start_col_i (sel_col),
    .win_mask_i  (sel_mask),
    .ilv_i       (sel_ilv),
    .beat_i      (beat_nxt),
    .col_o       (col_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_col  <= '0;
      hold_mask <= '0;
      hold_page <= 1'b0;
      hold_ilv  <= 1'b0;
      beat_q    <= '0;
      col_o     <= '0;
      valid_o   <= 1'b0;
      last_o    <= 1'b0;
    end else begin
      if (start_i) begin
        hold_col  <= start_col_i;
        hold_mask <= dec_mask;
        hold_page <= dec_page;
        hold_ilv  <= ilv_i & ~dec_page;
      end
      valid_o <= go_on;
      if (go_on) begin
        beat_q <= beat_nxt;
        col_o  <= col_nxt;
        last_o <= last_nxt;
      end else begin
        last_o <= 1'b0;
      end
    end
  end

  // ---------------- assertions ----------------
  p_start_beat0_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> valid_o && col_o == $past(start_col_i));

  p_last_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  p_end_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    valid_o && last_o && !start_i |=> !valid_o);

  p_stop_ends_r9: assert property (@(posedge clk) disable iff (rst)
    valid_o && stop_i && !start_i |=> !valid_o);

  p_page_no_last_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o && hold_page |-> !last_o);

  p_seq_step_r4: assert property (@(posedge clk) disable iff (rst)
    valid_o && !last_o && !stop_i && !start_i && !hold_ilv |=>
      ((col_o & hold_mask) == (($past(col_o) + COL_W'(1)) & hold_mask)));

  p_window_kept_r11: assert property (@(posedge clk) disable iff (rst)
    valid_o && !last_o && !stop_i && !start_i |=>
      ((col_o & ~hold_mask) == ($past(col_o) & ~hold_mask)));

endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             ilv_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
    .clk, .rst, .start_i, .start_col_i, .len_code_i, .ilv_i, .stop_i,
    .col_o, .valid_o, .last_o
  );

  typedef struct {
    bit    v;
    int    col;
    bit    last;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    fails = 0;
  string cur = "R2";
  bit    done = 1'b0;

  // reference model state
  bit m_v = 0;
  int m_i = 0;
  int m_s = 0;
  int m_bl = 1;
  bit m_il = 0;

  function automatic int len_of(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(int s, int bl, bit il, int i);
    int base;
    if (bl == 0) return (s + i) % 512;
    base = s - (s % bl);
    if (il) return base + ((s % bl) ^ i);
    return base + ((s % bl) + i) % bl;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic step(bit st, int c, int code, bit il, bit sp);
    exp_t e;
    bit   cur_last;
    @(negedge clk);
    start_i     = st;
    start_col_i = COL_W'(c);
    len_code_i  = 3'(code);
    ilv_i       = il;
    stop_i      = sp;
    cur_last = m_v && m_bl != 0 && m_i == m_bl - 1;
    if (st) begin
      m_v = 1; m_i = 0; m_s = c; m_bl = len_of(code); m_il = il;
    end else if (m_v && (sp || cur_last)) begin
      m_v = 0;
    end else if (m_v) begin
      m_i++;
    end
    e.v    = m_v;
    e.col  = m_v ? exp_col(m_s, m_bl, m_il, m_i) : 0;
    e.last = m_v && m_bl != 0 && m_i == m_bl - 1;
    e.tag  = cur;
    sb_q.push_back(e);
  endtask

  task automatic burst(int c, int code, bit il, int idles);
    step(1, c, code, il, 0);
    for (int k = 0; k < idles; k++) step(0, (c * 7 + k) % 512, (code + k) % 8, ~il, 0);
  endtask

  // monitor: sample 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (valid_o !== e.v || last_o !== e.last || (e.v && col_o !== COL_W'(e.col))) begin
        fails++;
        $display("FAIL %s: got v=%0b col=%0d last=%0b expected v=%0b col=%0d last=%0b",
                 e.tag, valid_o, col_o, last_o, e.v, e.col, e.last);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (valid_o !== 1'b0 || last_o !== 1'b0 || col_o !== '0) begin
      fails++;
      $display("FAIL R1: got v=%0b col=%0d last=%0b expected v=0 col=0 last=0", valid_o, col_o, last_o);
    end
    rst = 1'b0;
    @(posedge clk); #1;
    checks++;
    if (valid_o !== 1'b0 || last_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: got v=%0b last=%0b after reset expected v=0 last=0", valid_o, last_o);
    end

    cur = "R2";  burst(37, 0, 0, 3);
    cur = "R3";
    for (int cd = 0; cd < 7; cd++) burst(100 + cd * 17, cd, 0, 10);
    cur = "R4";  burst(13, 3, 0, 9); burst(6, 2, 0, 5); burst(511, 1, 0, 3);
    cur = "R5";  burst(13, 3, 1, 9); burst(6, 2, 1, 5); burst(255, 3, 1, 9); burst(3, 1, 1, 3);
    cur = "R8";  burst(5, 3, 0, 10);
    cur = "R6";  step(1, 500, 7, 0, 0);
    for (int k = 0; k < 600; k++) step(0, k % 512, k % 8, k[0], 0);
    step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    cur = "R7";  step(1, 3, 7, 1, 0);
    for (int k = 0; k < 20; k++) step(0, 9, 7, 1, 0);
    step(0, 0, 7, 1, 1); step(0, 0, 0, 0, 0);
    cur = "R9";  step(1, 0, 3, 0, 0); step(0, 0, 3, 0, 0); step(0, 0, 3, 0, 0);
    step(0, 0, 3, 0, 1); step(0, 0, 3, 0, 0); step(0, 0, 3, 0, 1); step(0, 0, 3, 0, 1);
    step(0, 0, 0, 0, 0);
    cur = "R10"; step(1, 40, 3, 0, 0); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    step(1, 200, 2, 1, 1); step(1, 77, 1, 0, 0); step(1, 300, 7, 1, 0);
    step(0, 0, 0, 0, 0); step(1, 9, 0, 0, 1);
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0);
    cur = "R11"; step(1, 8, 3, 0, 0);
    for (int k = 0; k < 9; k++) step(0, 400 + k, 7 - (k % 4), 1, 0);
    step(1, 21, 2, 1, 0);
    for (int k = 0; k < 5; k++) step(0, 300, 3, 0, 0);

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule